// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in, first-out store of 64 words held in flip-flops. A 6-bit stack pointer names the top word, and two flags report whether the stack is full or empty. Each clock cycle the block takes at most one request: either a push of the word on `push_data_i` or a pop of the top word.

The pointer does its arithmetic modulo 64. A push first moves the pointer up by one and then stores the incoming word at the new pointer. A pop first reads the word at the current pointer into an output register and then moves the pointer down by one. Full and empty are not found by counting stored words. The block sets FULL when a push wraps the pointer back to 0, and sets EMPTY when a pop brings the pointer down to 0. Word 0 therefore holds the 64th item.

There is no back-pressure. The requester reads `full_o` and `empty_o` and must not push into a full stack or pop from an empty one. A request that breaks this rule is dropped and reported with a one-cycle error pulse. Asserting push and pop in the same cycle is also dropped and reported. Popped data comes out with a one-cycle valid strobe. A valid/ready handshake would add nothing here, because the consumer has no means to stall a pop.

Top module: `rstack_top`

## Requirements
- R1: After reset, sp_o = 0, empty_o = 1, full_o = 0, err_o = 0 and pop_valid_o = 0.
- R2: An accepted push (push_i = 1, pop_i = 0, full_o = 0) makes sp_o equal to the old sp_o + 1 modulo 64 after the next rising edge, stores push_data_i at that new index, and leaves empty_o = 0.
- R3: An accepted push made when sp_o = 63 wraps sp_o to 0 and sets full_o = 1 after the same edge. A push that leaves sp_o nonzero leaves full_o = 0.
- R4: An accepted pop (pop_i = 1, push_i = 0, empty_o = 0) puts the word at index sp_o on pop_data_o, raises pop_valid_o for exactly the cycle after the edge, and makes sp_o equal to the old sp_o − 1 modulo 64. In all other cycles pop_valid_o is 0.
- R5: An accepted pop clears full_o. It sets empty_o exactly when the new sp_o is 0.
- R6: A push while full_o = 1 (without pop) leaves sp_o, the flags and every stored word unchanged, and raises err_o.
- R7: A pop while empty_o = 1 (without push) leaves sp_o and the flags unchanged, keeps pop_valid_o at 0, and raises err_o.
- R8: When push_i and pop_i are both 1, both requests are dropped, the state is unchanged, and err_o is raised.
- R9: Pops return the pushed words in reverse order, including the 64th word, which is stored at index 0.
- R10: err_o is a registered pulse, high for exactly the one cycle after each dropped request and low after accepted or idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| push_data_i | input | DW (8) | Word to push |
| pop_data_o | output | DW (8) | Registered popped word |
| pop_valid_o | output | 1 | pop_data_o was loaded by the last edge |
| sp_o | output | AW (6) | Stack pointer |
| full_o | output | 1 | Stack full flag |
| empty_o | output | 1 | Stack empty flag |
| err_o | output | 1 | One-cycle pulse for a dropped request |

## Verification
Every result is due one rising edge after the request that causes it. The pointer, the flags, the popped word, its valid strobe and the error pulse all change together at that edge, and none of them is visible in the request cycle. The bench drives inputs on the falling edge. It advances its own model at the same point and compares all outputs one time unit after the next rising edge. The error pulse and the valid strobe are checked in every cycle, so a value that lingers for a second cycle is caught as a mismatch.

// File: rtl/rstack_pkg.sv
package rstack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BAD  = 2'd3
  } stk_op_e;
endpackage

// File: rtl/rstack_ctrl.sv
module rstack_ctrl
  import rstack_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    full_i,
  input  logic    empty_i,
  output stk_op_e op_o
);
  // Classify this cycle's request against the current flags.
  always_comb begin
    unique case ({push_i, pop_i})
      2'b10:   op_o = full_i  ? OP_BAD : OP_PUSH;
      2'b01:   op_o = empty_i ? OP_BAD : OP_POP;
      2'b11:   op_o = OP_BAD;
      default: op_o = OP_IDLE;
    endcase
  end
endmodule

// File: rtl/rstack_ptr.sv
module rstack_ptr
  import rstack_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_op_e       op_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [AW-1:0] sp_q, sp_up, sp_dn;
  logic          full_q, empty_q;

  assign sp_up = sp_q + AW'(1);
  assign sp_dn = sp_q - AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      unique case (op_i)
        OP_PUSH: begin
          sp_q    <= sp_up;
          full_q  <= (sp_up == '0);
          empty_q <= 1'b0;
        end
        OP_POP: begin
          sp_q    <= sp_dn;
          empty_q <= (sp_dn == '0);
          full_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // The push address is the incremented pointer.
  assign wr_addr_o = sp_up;
  assign sp_o      = sp_q;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
endmodule

// File: rtl/rstack_mem.sv
module rstack_mem #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // One register word per slot, each with its own decoded load enable.
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DW-1:0] word_q;
    logic          load;
    assign load = we_i && (waddr_i == AW'(i));
    always_ff @(posedge clk) begin
      if (load) word_q <= wdata_i;
    end
    assign cells[i] = word_q;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/rstack_top.sv
module rstack_top
  import rstack_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] push_data_i,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o,
  output logic [AW-1:0] sp_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  stk_op_e       op;
  logic [AW-1:0] sp, wr_addr;
  logic [DW-1:0] rd_word;
  logic          full, empty;
  logic [DW-1:0] dr_q;
  logic          vld_q, err_q;

  rstack_ctrl u_ctrl (
    .push_i (push_i),
    .pop_i  (pop_i),
    .full_i (full),
    .empty_i(empty),
    .op_o   (op)
  );

  rstack_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op),
    .sp_o     (sp),
    .wr_addr_o(wr_addr),
    .full_o   (full),
    .empty_o  (empty)
  );

  rstack_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk    (clk),
    .we_i   (op == OP_PUSH),
    .waddr_i(wr_addr),
    .wdata_i(push_data_i),
    .raddr_i(sp),
    .rdata_o(rd_word)
  );

  // Data register: loads the top word on a pop, read before the pointer moves.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_q  <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= (op == OP_POP);
      err_q <= (op == OP_BAD);
      if (op == OP_POP) dr_q <= rd_word;
    end
  end

  assign pop_data_o  = dr_q;
  assign pop_valid_o = vld_q;
  assign err_o       = err_q;
  assign sp_o        = sp;
  assign full_o      = full;
  assign empty_o     = empty;
endmodule

// File: rtl/rstack_chk.sv
module rstack_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] sp_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          pop_valid_o,
  input logic          err_o
);
  // R3
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));

  // R2
  push_moves_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (sp_o == AW'($past(sp_o) + AW'(1))) && !empty_o);

  // R3
  push_wrap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o && sp_o == '1) |=> full_o && sp_o == '0);

  // R4
  pop_moves_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> pop_valid_o && (sp_o == AW'($past(sp_o) - AW'(1))));

  // R5
  pop_to_zero_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o && sp_o == AW'(1)) |=> empty_o && !full_o);

  // R6
  push_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> err_o && full_o && $stable(sp_o));

  // R7
  pop_empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> err_o && empty_o && !pop_valid_o && $stable(sp_o));

  // R8
  both_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> err_o && !pop_valid_o && $stable(sp_o));

  // R10
  idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> !err_o && !pop_valid_o && $stable(sp_o));
endmodule

bind rstack_top rstack_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .sp_o       (sp_o),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .pop_valid_o(pop_valid_o),
  .err_o      (err_o)
);

// File: tb/rstack_top_test.sv
module rstack_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0, pop_i = 1'b0;
  logic [DW-1:0] push_data_i = '0;
  logic [DW-1:0] pop_data_o;
  logic          pop_valid_o, full_o, empty_o, err_o;
  logic [AW-1:0] sp_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rstack_top #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .push_data_i(push_data_i), .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o),
    .sp_o(sp_o), .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model state
  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_sp;
  logic          m_full, m_empty, m_err, m_vld;
  logic [DW-1:0] m_data;

  function automatic bit is_bad(bit p, bit q, bit f, bit e);
    return (p && q) || (p && !q && f) || (q && !p && e);
  endfunction

  function automatic logic [AW-1:0] wrap_add(logic [AW-1:0] a, int d);
    return AW'(int'(a) + d);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, "sp", int'(sp_o), int'(m_sp));
    check(req, "full", int'(full_o), int'(m_full));
    check(req, "empty", int'(empty_o), int'(m_empty));
    check("R10", "err", int'(err_o), int'(m_err));
    check(req, "pop_valid", int'(pop_valid_o), int'(m_vld));
    if (m_vld) check("R9", "pop_data", int'(pop_data_o), int'(m_data));
  endtask

  // One cycle: drive at the falling edge, sample just after the rising edge.
  task automatic cyc(bit p, bit q, logic [DW-1:0] d);
    string req;
    bit    bd;
    @(negedge clk);
    push_i = p; pop_i = q; push_data_i = d;
    bd = is_bad(p, q, m_full, m_empty);
    m_err = bd; m_vld = 0;
    if (bd) begin
      req = (p && q) ? "R8" : (p ? "R6" : "R7");
    end else if (p) begin
      m_sp = wrap_add(m_sp, 1);
      m_mem[m_sp] = d;
      m_full = (m_sp == '0);
      m_empty = 0;
      req = m_full ? "R3" : "R2";
    end else if (q) begin
      m_data = m_mem[m_sp];
      m_vld = 1;
      m_sp = wrap_add(m_sp, -1);
      m_empty = (m_sp == '0);
      m_full = 0;
      req = m_empty ? "R5" : "R4";
    end else begin
      req = "R10";
    end
    @(posedge clk);
    #1;
    check_all(req);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    m_sp = '0; m_full = 0; m_empty = 1; m_err = 0; m_vld = 0; m_data = '0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "sp", int'(sp_o), 0);
    check("R1", "empty", int'(empty_o), 1);
    check("R1", "full", int'(full_o), 0);
    check("R1", "err", int'(err_o), 0);
    check("R1", "pop_valid", int'(pop_valid_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 pop from empty, R8 both at once
    cyc(0, 1, 8'h00);
    cyc(1, 1, 8'h11);
    cyc(0, 0, 8'h00);
    // Fill completely: R2, then R3 on the 64th push
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, DW'(8'hA0 + i));
    check("R3", "full after 64 pushes", int'(full_o), 1);
    // R6: push on full, twice back to back
    cyc(1, 0, 8'h5A);
    cyc(1, 0, 8'hC3);
    cyc(1, 1, 8'h77);
    // Drain: R9 order, R4/R5
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, 8'h00);
    check("R5", "empty after drain", int'(empty_o), 1);
    cyc(0, 1, 8'h00);
    // Partial fill and alternation
    for (int i = 0; i < 5; i++) cyc(1, 0, DW'($urandom));
    cyc(0, 1, 8'h00);
    cyc(1, 0, 8'h3C);
    cyc(0, 1, 8'h00);
    cyc(0, 1, 8'h00);

    // Random phases biased toward filling, then draining
    for (int ph = 0; ph < 12; ph++) begin
      int bias;
      bias = (ph % 2 == 0) ? 75 : 25;
      for (int k = 0; k < 250; k++) begin
        bit p, q;
        int r;
        r = int'($urandom % 100);
        p = (r < bias);
        q = (r >= bias) && (r < 95);
        if (r >= 97) begin p = 1; q = 1; end
        cyc(p, q, DW'($urandom));
      end
    end
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 1, 8'h00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule